// File: doc/BRIEF.md
# Multi-Device External Sync Arbiter

This block decides when the data path of a DAC interface instance may start moving samples. Software fires one-cycle control pulses: one arms a trigger, one cancels it, and one asks the block to emit a start event toward peer instances. While the trigger is armed, DMA samples are held back. The next rising edge on the external sync input, taken from a peer or from this instance's own start output, lets them go in every instance that listens to the same edge.

The gate only matters when DMA is the selected sample source. Any other source passes through whether the trigger is armed or not. When DMA is the source, a sample is accepted only when both the primary and the secondary DMA stream present valid data at the same time. The secondary stream keeps the two DMA engines lined up in the synchronized case.

The external sync input is asynchronous. It passes through a synchronizer chain before its rising edge is detected. A synthesis parameter removes the feature entirely. In that build the control pulses do nothing: the block never waits and never emits a start event.

Top module: `sync_arb_top`

## Requirements
- R1: After reset, sync_wait_o = 0, sync_start_o = 0 and release_o = 1. dma_ready_o = 0 while both valids are low.
- R2: An arm pulse without a disarm pulse in the same cycle sets sync_wait_o = 1 on the next clock. It stays 1 until a release event or a disarm pulse.
- R3: A disarm pulse clears sync_wait_o on the next clock. When arm and disarm are pulsed in the same cycle, disarm wins and sync_wait_o stays 0.
- R4: While armed, a 0-to-1 transition of ext_sync_i clears sync_wait_o on the third clock edge after the change. The input passes through two synchronizer flops and then an edge register.
- R5: A manual request pulse drives sync_start_o high for exactly one cycle, on the clock after the request.
- R6: While armed with DMA selected (src_dma_i = 1), release_o = 0 and dma_ready_o = 0, whatever the valids are.
- R7: When not armed and DMA is selected, release_o = 1 and dma_ready_o = dma_valid_pri_i AND dma_valid_sec_i.
- R8: With a non-DMA source (src_dma_i = 0), release_o = 1 even while armed, and dma_ready_o = 0.
- R9: With SYNC_EN = 0, the arm and manual request pulses have no effect: sync_wait_o and sync_start_o stay 0.
- R10: Only a rising edge triggers a release. A sync input that is already high when the trigger is armed does not release it. An edge that arrives while the trigger is not armed changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_pulse_i | input | 1 | One-cycle pulse that arms the trigger |
| disarm_pulse_i | input | 1 | One-cycle pulse that cancels the armed trigger |
| manual_req_i | input | 1 | One-cycle request to emit a start event |
| ext_sync_i | input | 1 | Asynchronous external sync input |
| src_dma_i | input | 1 | 1 when DMA is the selected sample source |
| dma_valid_pri_i | input | 1 | Primary DMA valid |
| dma_valid_sec_i | input | 1 | Secondary DMA valid |
| sync_start_o | output | 1 | Start event toward peer instances |
| sync_wait_o | output | 1 | 1 while armed and waiting for the sync edge |
| release_o | output | 1 | Channel data-path enable |
| dma_ready_o | output | 1 | Ready toward both DMA streams |

## Verification
The bench measures the exact release latency through the synchronizer. A design that samples the raw input, or skips the edge register, releases one or two cycles early.

It pulses arm and disarm together. A design with the wrong priority stays armed and starves the DMA.

It arms while the sync line is already high. A level-triggered design releases at once, where it should wait for a fresh edge.

It checks the manual start event for exact width and lag, and checks that a non-DMA source is never gated. A design that gated every source would freeze test patterns while the trigger is armed.

// File: rtl/sync_arb_pkg.sv
package sync_arb_pkg;

    // Registered state of the arm controller.
    typedef struct packed {
        logic armed;     // trigger armed, waiting for a sync edge
        logic ext_prev;  // previous synchronized sync level, for edge detection
        logic fire;      // outgoing start event
    } arb_state_t;

    localparam arb_state_t ARB_RESET = '0;

endpackage

// File: rtl/sync_arb_cdc.sv
module sync_arb_cdc #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];

    // R4: the first flop captures the raw input one clock later
    p_first_stage_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (chain_q[0] == $past(async_i)));

endmodule

// File: rtl/sync_arb_ctrl.sv
module sync_arb_ctrl
    import sync_arb_pkg::*;
#(
    parameter bit SYNC_EN = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    input  logic disarm_i,
    input  logic manual_i,
    input  logic ext_s_i,
    output logic armed_o,
    output logic fire_o
);
    arb_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d          = st_q;
        rise          = ext_s_i & ~st_q.ext_prev;
        st_d.ext_prev = ext_s_i;
        if (SYNC_EN) begin
            if (disarm_i)                st_d.armed = 1'b0;
            else if (st_q.armed && rise) st_d.armed = 1'b0;
            else if (arm_i)              st_d.armed = 1'b1;
            st_d.fire = manual_i;
        end else begin
            st_d.armed = 1'b0;
            st_d.fire  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ARB_RESET;
        else         st_q <= st_d;
    end

    assign armed_o = st_q.armed;
    assign fire_o  = st_q.fire;

    // R3: disarm always leaves the trigger idle
    p_disarm_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        disarm_i |=> !armed_o);

    // R5: no request, no start event
    p_no_spurious_fire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !manual_i |=> !fire_o);

    // R10: without arming, an idle trigger stays idle
    p_idle_stays_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!armed_o && !arm_i) |=> !armed_o);

    generate
        if (SYNC_EN) begin : g_en_checks
            // R2: arm alone sets the trigger
            p_arm_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (arm_i && !disarm_i && !armed_o) |=> armed_o);
            // R4: an edge while armed releases
            p_edge_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (armed_o && ext_s_i && !st_q.ext_prev) |=> !armed_o);
            // R5: a request appears one cycle later
            p_fire_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                manual_i |=> fire_o);
        end else begin : g_off_checks
            // R9: feature removed, never waits
            p_off_never_armed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
                arm_i |=> !armed_o);
        end
    endgenerate

endmodule

// File: rtl/sync_arb_gate.sv
module sync_arb_gate (
    input  logic armed_i,
    input  logic src_dma_i,
    input  logic valid_pri_i,
    input  logic valid_sec_i,
    output logic release_o,
    output logic ready_o
);
    logic hold;

    always_comb begin
        hold      = armed_i & src_dma_i;
        release_o = ~hold;
        ready_o   = src_dma_i & ~hold & valid_pri_i & valid_sec_i;
    end

endmodule

// File: rtl/sync_arb_top.sv
module sync_arb_top #(
    parameter bit SYNC_EN     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_pulse_i,
    input  logic disarm_pulse_i,
    input  logic manual_req_i,
    input  logic ext_sync_i,
    input  logic src_dma_i,
    input  logic dma_valid_pri_i,
    input  logic dma_valid_sec_i,
    output logic sync_start_o,
    output logic sync_wait_o,
    output logic release_o,
    output logic dma_ready_o
);
    logic ext_s;
    logic armed;

    sync_arb_cdc #(.STAGES(SYNC_STAGES)) u_cdc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ext_sync_i),
        .sync_o  (ext_s)
    );

    sync_arb_ctrl #(.SYNC_EN(SYNC_EN)) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .arm_i    (arm_pulse_i),
        .disarm_i (disarm_pulse_i),
        .manual_i (manual_req_i),
        .ext_s_i  (ext_s),
        .armed_o  (armed),
        .fire_o   (sync_start_o)
    );

    sync_arb_gate u_gate (
        .armed_i     (armed),
        .src_dma_i   (src_dma_i),
        .valid_pri_i (dma_valid_pri_i),
        .valid_sec_i (dma_valid_sec_i),
        .release_o   (release_o),
        .ready_o     (dma_ready_o)
    );

    assign sync_wait_o = armed;

    // R6: waiting on DMA keeps the data path shut
    p_hold_while_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_wait_o && src_dma_i) |-> (!release_o && !dma_ready_o));

    // R7: a ready needs both streams valid
    p_ready_both_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_ready_o |-> (dma_valid_pri_i && dma_valid_sec_i));

    // R8: other sources are never gated
    p_non_dma_open_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !src_dma_i |-> (release_o && !dma_ready_o));

endmodule

// File: tb/sync_arb_top_tb_top.sv
module sync_arb_top_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 0, disarm = 0, manual = 0, ext = 0, src_dma = 1, vp = 0, vs = 0;
    logic start_o, wait_o, rel_o, rdy_o;
    logic start_off, wait_off, rel_off, rdy_off;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_arb_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .arm_pulse_i(arm), .disarm_pulse_i(disarm),
        .manual_req_i(manual), .ext_sync_i(ext), .src_dma_i(src_dma),
        .dma_valid_pri_i(vp), .dma_valid_sec_i(vs),
        .sync_start_o(start_o), .sync_wait_o(wait_o),
        .release_o(rel_o), .dma_ready_o(rdy_o));

    sync_arb_top #(.SYNC_EN(1'b0)) dut_off_i (
        .clk_i(clk), .rst_ni(rst_n), .arm_pulse_i(arm), .disarm_pulse_i(disarm),
        .manual_req_i(manual), .ext_sync_i(ext), .src_dma_i(src_dma),
        .dma_valid_pri_i(vp), .dma_valid_sec_i(vs),
        .sync_start_o(start_off), .sync_wait_o(wait_off),
        .release_o(rel_off), .dma_ready_o(rdy_off));

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_arm();
        arm = 1; @(negedge clk); arm = 0;
    endtask

    task automatic pulse_disarm();
        disarm = 1; @(negedge clk); disarm = 0;
    endtask

    task automatic t_reset();
        check("R1 wait", wait_o, 0);
        check("R1 start", start_o, 0);
        check("R1 release", rel_o, 1);
        check("R1 ready", rdy_o, 0);
    endtask

    task automatic t_arm_release();
        pulse_arm();
        check("R2 wait after arm", wait_o, 1);
        idle(3);
        check("R2 wait held", wait_o, 1);
        ext = 1;
        @(negedge clk);
        check("R4 wait after 1 edge", wait_o, 1);
        @(negedge clk);
        check("R4 wait after 2 edges", wait_o, 1);
        @(negedge clk);
        check("R4 released after 3 edges", wait_o, 0);
        check("R4 release high", rel_o, 1);
        ext = 0;
        idle(4);
    endtask

    task automatic t_disarm();
        pulse_arm();
        check("R3 armed before disarm", wait_o, 1);
        pulse_disarm();
        check("R3 disarm clears", wait_o, 0);
        arm = 1; disarm = 1;
        @(negedge clk);
        arm = 0; disarm = 0;
        check("R3 disarm wins", wait_o, 0);
        idle(2);
        check("R3 still idle", wait_o, 0);
    endtask

    task automatic t_manual();
        manual = 1;
        @(negedge clk);
        manual = 0;
        check("R5 start high", start_o, 1);
        @(negedge clk);
        check("R5 start one cycle", start_o, 0);
    endtask

    task automatic t_gating();
        src_dma = 1; vp = 1; vs = 1;
        pulse_arm();
        check("R6 release low while armed", rel_o, 0);
        check("R6 ready low while armed", rdy_o, 0);
        pulse_disarm();
        check("R7 release high", rel_o, 1);
        check("R7 ready both valid", rdy_o, 1);
        vs = 0; @(negedge clk);
        check("R7 ready sec low", rdy_o, 0);
        vs = 1; vp = 0; @(negedge clk);
        check("R7 ready pri low", rdy_o, 0);
        vp = 0; vs = 0;
    endtask

    task automatic t_non_dma();
        src_dma = 0; vp = 1; vs = 1;
        pulse_arm();
        check("R8 wait set", wait_o, 1);
        check("R8 release open", rel_o, 1);
        check("R8 ready low", rdy_o, 0);
        pulse_disarm();
        src_dma = 1; vp = 0; vs = 0;
    endtask

    task automatic t_level();
        ext = 1;
        idle(5);
        check("R10 edge while idle ignored", wait_o, 0);
        pulse_arm();
        idle(5);
        check("R10 high level no release", wait_o, 1);
        pulse_disarm();
        ext = 0;
        idle(4);
    endtask

    task automatic t_disabled();
        src_dma = 1; vp = 1; vs = 1;
        pulse_arm();
        check("R9 off wait", wait_off, 0);
        check("R9 off ready", rdy_off, 1);
        manual = 1; @(negedge clk); manual = 0;
        check("R9 off start", start_off, 0);
        pulse_disarm();
        vp = 0; vs = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL WATCHDOG actual=expired expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(2);
        t_reset();
        t_arm_release();
        t_disarm();
        t_manual();
        t_gating();
        t_non_dma();
        t_level();
        t_disabled();
        idle(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule